// File: doc/BRIEF.md
# Low-Transition Multi-Chain Scan Stimulus Generator

This block produces built-in self-test stimulus for a full-scan design that has several scan chains of equal depth and a group of primary inputs. A linear feedback shift register supplies a seed word, and a Johnson-style register supplies a single-input-change vector. During loading, every chain receives the same rotating Johnson codeword, inverted or not by its own seed bit. As a result, consecutive chain loads differ in only one position, so the chains switch far less than they would if fed directly from the LFSR.

A controller runs the test-per-scan procedure with one clock and internal enables. For each seed it steps the LFSR once. It then walks the Johnson register through all of its states. For each state it rotates the register once per shift cycle so that every chain is filled, and then it issues a capture. After the programmed number of seeds, it raises a done flag and holds it.

Top module: `lowtrans_scan_tpg`

## Requirements
- R1: After reset, `scan_en`, `capture` and `done` are 0, `scan_in` is all zeros and `pi_vec` equals the parameter `SEED_INIT`.
- R2: The seed register advances exactly once at the start of each seed iteration. The new value is the old value shifted one place toward the MSB, with bit 0 set to the XOR of the old bits selected by the mask `LFSR_TAPS`. A `start` reloads `SEED_INIT` first, so the first seed is one step beyond it.
- R3: `pi_vec` always shows the seed register. It holds the same value from the Johnson step of a seed iteration to that iteration's last capture.
- R4: A `start` clears the Johnson register to all zeros. Each Johnson step moves every bit up one place and puts the inverse of the top bit (index `CHAIN_LEN-1`) into bit 0.
- R5: For each Johnson vector the block spends one quiet step cycle, then `CHAIN_LEN` cycles with `scan_en`=1, then one cycle with `capture`=1 and `scan_en`=0.
- R6: In every shift cycle, `scan_in[i]` equals seed bit i XOR Johnson bit `CHAIN_LEN-1`. After each shift the register rotates up one place, with the top bit wrapping to bit 0. Shift cycle c therefore carries Johnson bit `CHAIN_LEN-1-c`.
- R7: `scan_in` is all zeros in every cycle in which `scan_en` is 0.
- R8: Each seed covers `2*CHAIN_LEN` Johnson vectors. After `seed_limit` seeds, `done` rises exactly `seed_limit*(1+2*CHAIN_LEN*(CHAIN_LEN+2))` clock edges after the edge that samples `start`.
- R9: A `start` with `seed_limit`=0 sets `done` at the sampling edge and produces no shift or capture.
- R10: `start` has no effect while a run is in progress. A `start` sampled in the idle or done state begins a new run, which reloads the seed and clears the Johnson register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when the block is idle or done |
| seed_limit | input | LIM_W | Number of seeds to apply, latched at start |
| scan_in | output | NCHAIN | Serial data, one bit per scan chain |
| scan_en | output | 1 | High during the shift cycles |
| capture | output | 1 | One-cycle capture strobe |
| pi_vec | output | NPI | Seed word driven onto the primary inputs |
| done | output | 1 | Run finished; held until the next start |

## Verification
The bench builds the block with three chains of depth five and a 7-bit seed register using the primitive polynomial x^7+x^6+1. With these values a single seed iteration takes 71 cycles, so all ten Johnson states, both Johnson half-cycles and several seed changes are covered within a few hundred cycles. Three chains on a 7-bit seed are enough to show that each chain gets its own seed bit while the unused seed bits still appear on the primary inputs. Runs of zero, one and several seeds, together with start pulses issued in the middle of a run, exercise the count, the restart path and the ignore path against a cycle-indexed model.

// File: rtl/lowtrans_scan_tpg.sv
module lowtrans_scan_tpg #(
  parameter int NCHAIN    = 4,
  parameter int CHAIN_LEN = 8,
  parameter int NPI       = 8,
  parameter logic [NPI-1:0] LFSR_TAPS = 8'hB8,
  parameter logic [NPI-1:0] SEED_INIT = 1,
  parameter int LIM_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LIM_W-1:0]  seed_limit,
  output logic [NCHAIN-1:0] scan_in,
  output logic              scan_en,
  output logic              capture,
  output logic [NPI-1:0]    pi_vec,
  output logic              done
);
  localparam int SH_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam int VC_W = $clog2(2*CHAIN_LEN + 1);
  localparam logic [SH_W-1:0] SH_LAST = SH_W'(CHAIN_LEN - 1);
  localparam logic [VC_W-1:0] VC_LAST = VC_W'(2*CHAIN_LEN - 1);

  typedef enum logic [2:0] {S_IDLE, S_SEED, S_STEP, S_SHIFT, S_CAPT, S_DONE} st_t;

  st_t              st;
  logic [NPI-1:0]       lfsr;
  logic [CHAIN_LEN-1:0] jv;
  logic [SH_W-1:0]      shc;
  logic [VC_W-1:0]      vc;
  logic [LIM_W-1:0]     sc, lim_q;

  wire [NPI-1:0] lfsr_nxt = {lfsr[NPI-2:0], ^(lfsr & LFSR_TAPS)};
  wire           last_seed = ({1'b0, sc} + 1'b1) == {1'b0, lim_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      lfsr  <= SEED_INIT;
      jv    <= '0;
      shc   <= '0;
      vc    <= '0;
      sc    <= '0;
      lim_q <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE: if (start) begin
          lfsr  <= SEED_INIT;
          jv    <= '0;
          sc    <= '0;
          vc    <= '0;
          lim_q <= seed_limit;
          st    <= (seed_limit == '0) ? S_DONE : S_SEED;
        end
        S_SEED: begin
          lfsr <= lfsr_nxt;
          vc   <= '0;
          st   <= S_STEP;
        end
        S_STEP: begin
          jv  <= {jv[CHAIN_LEN-2:0], ~jv[CHAIN_LEN-1]};
          shc <= '0;
          st  <= S_SHIFT;
        end
        S_SHIFT: begin
          jv  <= {jv[CHAIN_LEN-2:0], jv[CHAIN_LEN-1]};
          shc <= shc + 1'b1;
          if (shc == SH_LAST) st <= S_CAPT;
        end
        S_CAPT: begin
          vc <= vc + 1'b1;
          if (vc == VC_LAST) begin
            sc <= sc + 1'b1;
            st <= last_seed ? S_DONE : S_SEED;
          end else begin
            st <= S_STEP;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign scan_en = (st == S_SHIFT);
  assign capture = (st == S_CAPT);
  assign done    = (st == S_DONE);
  assign pi_vec  = lfsr;
  assign scan_in = scan_en ? (lfsr[NCHAIN-1:0] ^ {NCHAIN{jv[CHAIN_LEN-1]}}) : '0;

  initial begin
    a_r2_seed_width: assert (NPI >= NCHAIN && CHAIN_LEN >= 2);
  end

  a_r5_capture_after_shift: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> $past(scan_en));
  a_r5_capture_single: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> !capture);
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(capture && scan_en));
  a_r3_seed_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en || capture) && $past(scan_en) |-> $stable(pi_vec));
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !scan_en && !capture);
  a_r2_seed_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    pi_vec != '0);
  a_r4_johnson_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_en) |-> !$past(scan_en) && !$past(capture));
endmodule

// File: tb/lowtrans_scan_tpg_bench.sv
module lowtrans_scan_tpg_bench;
  localparam int M = 3, L = 5, NP = 7, LW = 8;
  localparam logic [NP-1:0] TAPS = 7'h60;
  localparam logic [NP-1:0] INIT = 7'h15;
  localparam int P = 1 + 2*L*(L+2);

  logic clk = 0, rst_n = 0, start = 0;
  logic [LW-1:0] seed_limit = '0;
  logic [M-1:0] scan_in;
  logic scan_en, capture, done;
  logic [NP-1:0] pi_vec;
  int n_chk = 0, n_bad = 0;
  bit timed_out = 0;

  always #2 clk = ~clk;

  lowtrans_scan_tpg #(.NCHAIN(M), .CHAIN_LEN(L), .NPI(NP), .LFSR_TAPS(TAPS),
    .SEED_INIT(INIT), .LIM_W(LW)) u_lowtrans_scan_tpg (
    .clk(clk), .rst_n(rst_n), .start(start), .seed_limit(seed_limit),
    .scan_in(scan_in), .scan_en(scan_en), .capture(capture),
    .pi_vec(pi_vec), .done(done));

  function automatic logic [NP-1:0] seed_at(int k);
    logic [NP-1:0] s = INIT;
    for (int i = 0; i < k; i++) s = {s[NP-2:0], ^(s & TAPS)};
    return s;
  endfunction

  function automatic logic jbit(int v, int b);
    if (v <= L) return b < v;
    return b >= v - L;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(int n, int mid);
    int total = n * P;
    @(negedge clk);
    start = 1; seed_limit = LW'(n);
    for (int t = 0; t <= total + 1; t++) begin
      @(negedge clk);
      start = (mid >= 0 && t == mid) ? 1'b1 : 1'b0;
      if (t >= total) begin
        chk(done === 1'b1, "R8/R9 done", done, 1);
        chk(!scan_en && !capture, "R9 quiet after done", {scan_en, capture}, 0);
        chk(pi_vec === seed_at(n), "R3 seed at done", pi_vec, seed_at(n));
      end else begin
        int k = t / P, r = t % P;
        bit e_sh = 0, e_cp = 0;
        logic [M-1:0] e_in = '0;
        logic [NP-1:0] e_pi = seed_at(r == 0 ? k : k + 1);
        if (r >= 1) begin
          int q = r - 1, v = q / (L+2) + 1, ph = q % (L+2);
          if (ph >= 1 && ph <= L) begin
            e_sh = 1;
            e_in = e_pi[M-1:0] ^ {M{jbit(v, L - ph)}};
          end
          e_cp = (ph == L + 1);
        end
        chk(done === 1'b0, "R10 done low during run", done, 0);
        chk(scan_en === e_sh, "R5 scan_en", scan_en, e_sh);
        chk(capture === e_cp, "R5 capture", capture, e_cp);
        chk(pi_vec === e_pi, "R2/R3 pi_vec", pi_vec, e_pi);
        if (e_sh) chk(scan_in === e_in, "R6/R4 scan_in", scan_in, e_in);
        else      chk(scan_in === '0, "R7 scan_in idle", scan_in, 0);
      end
    end
    start = 0;
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(!scan_en && !capture && !done, "R1 controls", {scan_en, capture, done}, 0);
    chk(scan_in === '0, "R1 scan_in", scan_in, 0);
    chk(pi_vec === INIT, "R1 pi_vec", pi_vec, INIT);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run(0, -1);
    run(1, -1);
    run(3, 40);
    run(2, 100);
    for (int i = 0; i < 4; i++) begin
      int n = 1 + int'($urandom_range(3));
      int mid = int'($urandom_range(n * P - 3));
      run(n, mid);
    end
    run(0, -1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    timed_out = 1;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule